// File: doc/BRIEF.md
# Fourth-Order MASH Fractional Divider Modulator

This block produces the division ratio for a fractional-N frequency synthesizer. Once per comparison cycle the divider pulses an update strobe. On that strobe the block advances a cascade of four equal-width accumulators. The first accumulator is fed by a fixed-point fraction word. Each later accumulator is fed by the freshly updated content of the stage before it.

Every accumulator gives a one-bit overflow on each update. Delay flops keep a short history of these bits. The current and delayed overflows are combined with binomial noise-cancellation weights into a small signed correction. The correction is added to the integer command and registered as the next divisor. Over many updates the mean divisor equals the integer command plus the fraction word divided by 2^32. The quantisation noise is shaped to high offsets, where the loop filter removes it.

The cascade depth, the accumulator width and the integer width are parameters. The correction weights are derived from the depth: stage k (counted from 0) uses the coefficients of (1 - z^-1)^k. All state sits behind an asynchronous active-low reset that is released synchronously inside the block.

Top module: `mash4_frac_mod`

## Requirements
- R1: After reset, the divisor output, all accumulators and all overflow delay flops are zero.
- R2: When the update strobe is low at a clock edge, neither the divisor output nor any accumulator changes. Updates resume from the held state.
- R3: On an update, stage 0 adds the fraction word to its accumulator modulo 2^32. Its overflow bit is the carry out of bit 31.
- R4: On an update, each stage k>0 adds the post-update content of stage k-1 to its own accumulator modulo 2^32, with the carry out as its overflow bit.
- R5: The correction is c0[n] + (c1[n] - c1[n-1]) + (c2[n] - 2c2[n-1] + c2[n-2]) + (c3[n] - 3c3[n-1] + 3c3[n-2] - c3[n-3]). Here ck[n-d] is the overflow of stage k from d updates earlier, and the history counts only strobed updates.
- R6: The correction (divisor minus integer command, read as a signed 8-bit value) always lies between -7 and +8.
- R7: The divisor is (N + correction) mod 256. It is registered and appears on the output from the clock edge that samples the strobe.
- R8: From reset with the fraction held at zero, every update yields a divisor equal to N.
- R9: From reset with a fixed fraction F and a fixed N, the sum of corrections over M updates stays within 7 of floor(M*F/2^32).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| upd_i | input | 1 | Update strobe, high for one clock per comparison cycle |
| int_i | input | 8 | Integer part of the division command |
| frac_i | input | 32 | Fraction word, unsigned, in units of 2^-32 |
| div_o | output | 8 | Registered divisor for the next divider cycle |

## Verification
The bench uses the default parameters: four stages, 32-bit accumulators and an 8-bit integer. These are the only values at which the R5 weights and the R6 bounds take their stated form. With full 32-bit fractions near zero and near 2^32, the cascade reaches the extreme corrections -7 and +8. Integer commands of 0 and 252 then carry the sum across both ends of the modulo-256 range. Long runs of thousands of updates give the telescoping bound of R9 room to show, and strobes alternating with idle gaps test that the history advances only on updates.

// File: rtl/mash_pkg.sv
package mash_pkg;

  // binomial coefficient C(n,k), exact for the small orders used here
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = (r * (n - i)) / (i + 1);
    return r;
  endfunction

  // signed weight of stage k on its overflow delayed by d updates
  function automatic int tap_weight(input int k, input int d);
    return ((d % 2) == 1) ? -binom(k, d) : binom(k, d);
  endfunction

  // largest correction the cascade can produce
  function automatic int corr_max(input int order);
    int s;
    s = 0;
    for (int k = 0; k < order; k++)
      for (int d = 0; d <= k; d++)
        if (tap_weight(k, d) > 0) s += tap_weight(k, d);
    return s;
  endfunction

  // smallest correction the cascade can produce
  function automatic int corr_min(input int order);
    int s;
    s = 0;
    for (int k = 0; k < order; k++)
      for (int d = 0; d <= k; d++)
        if (tap_weight(k, d) < 0) s += tap_weight(k, d);
    return s;
  endfunction

endpackage

// File: rtl/mash_rst_sync.sv
module mash_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] add_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             carry_o,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W:0]   wide_sum;

  always_comb begin
    wide_sum = {1'b0, acc_q} + {1'b0, add_i};
    sum_o    = wide_sum[ACC_W-1:0];
    carry_o  = wide_sum[ACC_W];
    acc_d    = en_i ? wide_sum[ACC_W-1:0] : acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/mash_carry_hist.sv
module mash_carry_hist #(
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             c_i,
  output logic [DEPTH-1:0] hist_o
);

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;

  // hist_q[i] holds the overflow from i+1 updates ago
  always_comb begin
    hist_d = hist_q;
    if (en_i) begin
      hist_d[0] = c_i;
      for (int i = 1; i < DEPTH; i++) hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/mash_noise_comb.sv
module mash_noise_comb
  import mash_pkg::*;
#(
  parameter int ORDER  = 4,
  parameter int CORR_W = ORDER + 2
) (
  input  logic [ORDER-1:0]            c_i,
  input  logic [ORDER-1:0][ORDER-1:0] hist_i,
  output logic signed [CORR_W-1:0]    corr_o
);

  always_comb begin : weigh
    int s;
    s = 0;
    for (int k = 0; k < ORDER; k++) begin
      if (c_i[k]) s += tap_weight(k, 0);
      for (int d = 1; d <= k; d++)
        if (hist_i[k][d-1]) s += tap_weight(k, d);
    end
    corr_o = CORR_W'(s);
  end

endmodule

// File: rtl/mash4_frac_mod.sv
module mash4_frac_mod #(
  parameter int ORDER = 4,
  parameter int ACC_W = 32,
  parameter int INT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [ACC_W-1:0] frac_i,
  output logic [INT_W-1:0] div_o
);

  localparam int CORR_W = ORDER + 2;

  logic                            rst_sync_n;
  logic [ORDER-1:0][ACC_W-1:0]     stage_in;
  logic [ORDER-1:0][ACC_W-1:0]     stage_sum;
  logic [ORDER-1:0][ACC_W-1:0]     acc_vec;
  logic [ORDER-1:0]                carry_now;
  logic [ORDER-1:0][ORDER-1:0]     hist_all;
  logic signed [CORR_W-1:0]        corr;
  logic [INT_W-1:0]                div_q;
  logic [INT_W-1:0]                div_d;

  mash_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stage_in[k] = frac_i;
      assign hist_all[k] = '0;
    end else begin : g_next
      logic [k-1:0] hist_k;
      assign stage_in[k] = stage_sum[k-1];
      mash_carry_hist #(.DEPTH(k)) u_hist (
        .clk_i  (clk_i),
        .rst_ni (rst_sync_n),
        .en_i   (upd_i),
        .c_i    (carry_now[k]),
        .hist_o (hist_k)
      );
      assign hist_all[k] = ORDER'(hist_k);
    end

    mash_acc_stage #(.ACC_W(ACC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .en_i    (upd_i),
      .add_i   (stage_in[k]),
      .sum_o   (stage_sum[k]),
      .carry_o (carry_now[k]),
      .acc_o   (acc_vec[k])
    );
  end

  mash_noise_comb #(.ORDER(ORDER), .CORR_W(CORR_W)) u_comb (
    .c_i    (carry_now),
    .hist_i (hist_all),
    .corr_o (corr)
  );

  always_comb begin
    div_d = upd_i ? (int_i + INT_W'(corr)) : div_q;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) div_q <= '0;
    else             div_q <= div_d;
  end

  assign div_o = div_q;

endmodule

// File: rtl/mash4_frac_mod_chk.sv
module mash4_frac_mod_chk
  import mash_pkg::*;
#(
  parameter int ORDER = 4,
  parameter int ACC_W = 32,
  parameter int INT_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_n,
  input  logic                        upd_i,
  input  logic [INT_W-1:0]            int_i,
  input  logic [ACC_W-1:0]            frac_i,
  input  logic [INT_W-1:0]            div_o,
  input  logic [ORDER-1:0][ACC_W-1:0] acc_i
);

  localparam int CMAX = corr_max(ORDER);
  localparam int CMIN = corr_min(ORDER);

  logic                        upd_d;
  logic [INT_W-1:0]            int_d;
  logic [ACC_W-1:0]            frac_d;
  logic [ORDER-1:0][ACC_W-1:0] acc_d;
  logic [ORDER-1:0][ORDER-1:0] h_q;
  logic [ORDER-1:0]            c_obs;
  int                          exp_corr;
  logic signed [INT_W-1:0]     seen_corr;

  // overflow is observed as a wrap of the accumulator value
  always_comb begin
    for (int k = 0; k < ORDER; k++) c_obs[k] = acc_i[k] < acc_d[k];
    exp_corr = 0;
    for (int k = 0; k < ORDER; k++) begin
      if (c_obs[k]) exp_corr += tap_weight(k, 0);
      for (int d = 1; d <= k; d++)
        if (h_q[k][d-1]) exp_corr += tap_weight(k, d);
    end
    seen_corr = div_o - int_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      upd_d  <= 1'b0;
      int_d  <= '0;
      frac_d <= '0;
      acc_d  <= '0;
      h_q    <= '0;
    end else begin
      upd_d  <= upd_i;
      int_d  <= int_i;
      frac_d <= frac_i;
      acc_d  <= acc_i;
      if (upd_d) begin
        for (int k = 0; k < ORDER; k++) begin
          h_q[k][0] <= c_obs[k];
          for (int d = 1; d < ORDER; d++) h_q[k][d] <= h_q[k][d-1];
        end
      end
    end
  end

  assert_div_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !upd_d |-> $stable(div_o));

  assert_acc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !upd_d |-> (acc_i == acc_d));

  assert_stage0_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    upd_d |-> (acc_i[0] == acc_d[0] + frac_d));

  for (genvar k = 1; k < ORDER; k++) begin : g_casc
    assert_cascade_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
      upd_d |-> (acc_i[k] == acc_d[k] + acc_i[k-1]));
  end

  assert_weighted_div_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    upd_d |-> (div_o == INT_W'(int'(int_d) + exp_corr)));

  assert_corr_range_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    upd_d |-> ((int'(seen_corr) >= CMIN) && (int'(seen_corr) <= CMAX)));

endmodule

bind mash4_frac_mod mash4_frac_mod_chk #(
  .ORDER (ORDER),
  .ACC_W (ACC_W),
  .INT_W (INT_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_sync_n),
  .upd_i  (upd_i),
  .int_i  (int_i),
  .frac_i (frac_i),
  .div_o  (div_o),
  .acc_i  (acc_vec)
);

// File: tb/mash4_frac_mod_tb.sv
module mash4_frac_mod_tb;

  logic        clk;
  logic        rst_n;
  logic        upd;
  logic [7:0]  n_cmd;
  logic [31:0] f_cmd;
  logic [7:0]  div;

  int n_cmp;
  int n_bad;
  logic pend;

  byte unsigned exp_q[$];
  byte unsigned nq[$];
  string        tag_q[$];

  // behavioural model state
  logic [31:0] m_acc [4];
  logic        m_h1;
  logic [1:0]  m_h2;
  logic [2:0]  m_h3;
  longint      corr_sum;

  mash4_frac_mod u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .upd_i  (upd),
    .int_i  (n_cmd),
    .frac_i (f_cmd),
    .div_o  (div)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) m_acc[i] = '0;
    m_h1 = 1'b0; m_h2 = '0; m_h3 = '0;
  endtask

  task automatic model_step(input logic [7:0] n, input logic [31:0] f, output logic [7:0] d);
    logic [32:0] s;
    logic [3:0]  c;
    int          corr;
    s = {1'b0, m_acc[0]} + {1'b0, f};         c[0] = s[32]; m_acc[0] = s[31:0];
    s = {1'b0, m_acc[1]} + {1'b0, m_acc[0]};  c[1] = s[32]; m_acc[1] = s[31:0];
    s = {1'b0, m_acc[2]} + {1'b0, m_acc[1]};  c[2] = s[32]; m_acc[2] = s[31:0];
    s = {1'b0, m_acc[3]} + {1'b0, m_acc[2]};  c[3] = s[32]; m_acc[3] = s[31:0];
    corr = int'(c[0]) + int'(c[1]) - int'(m_h1)
         + int'(c[2]) - 2*int'(m_h2[0]) + int'(m_h2[1])
         + int'(c[3]) - 3*int'(m_h3[0]) + 3*int'(m_h3[1]) - int'(m_h3[2]);
    m_h1 = c[1];
    m_h2 = {m_h2[0], c[2]};
    m_h3 = {m_h3[1:0], c[3]};
    d = 8'(int'(n) + corr);
  endtask

  // driver: one strobe per call, back-to-back when called in a row
  task automatic step(input logic [7:0] n, input logic [31:0] f, input string tag);
    logic [7:0] e;
    @(negedge clk);
    upd = 1'b1; n_cmd = n; f_cmd = f;
    model_step(n, f, e);
    exp_q.push_back(e); nq.push_back(n); tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle(input int cycles);
    @(negedge clk);
    upd = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    upd = 1'b0; rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops one expected item per strobe, one cycle later
  always @(posedge clk) pend <= upd;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "queue", int'(div), -1);
      end else begin
        byte unsigned e;
        byte unsigned n;
        string        t;
        logic signed [7:0] dc;
        e = exp_q.pop_front(); n = nq.pop_front(); t = tag_q.pop_front();
        check(div == e, t, int'(div), int'(e));
        dc = div - n;
        check(int'(dc) >= -7 && int'(dc) <= 8, "R6 range", int'(dc), 0);
        corr_sum += longint'(dc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  held;
    logic [31:0] lf;
    longint      ideal;
    longint      diff;
    n_cmp = 0; n_bad = 0; pend = 1'b0; corr_sum = 0;
    upd = 1'b0; n_cmd = '0; f_cmd = '0; rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check(div == 8'd0, "R1 in reset", int'(div), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(div == 8'd0, "R1 after release", int'(div), 0);

    // R8: zero fraction leaves the integer untouched
    for (int i = 0; i < 30; i++) step(8'(100 + i), 32'd0, "R8 zero fraction");
    idle(2);
    check(div == 8'd129, "R8 last value", int'(div), 129);

    // R3 R4 R5: golden-ratio fraction
    for (int i = 0; i < 300; i++) step(8'd60, 32'h9E37_79B9, "R3 R4 R5 cascade");
    idle(2);

    // R7: wrap below zero and above 255
    for (int i = 0; i < 200; i++) step(8'd0, 32'h0000_0007, "R7 low wrap");
    for (int i = 0; i < 200; i++) step(8'd0, 32'hF000_0001, "R7 low wrap big F");
    for (int i = 0; i < 150; i++) step(8'd252, 32'hFFFF_FFFF, "R7 high wrap");
    idle(2);

    // R2: long idle, output holds, then history resumes where it stopped
    held = div;
    idle(40);
    check(div == held, "R2 hold", int'(div), int'(held));
    for (int i = 0; i < 5; i++) begin
      step(8'd90, 32'h1234_5678, "R2 resume");
      idle(3);
      held = div;
      idle(7);
      check(div == held, "R2 gap hold", int'(div), int'(held));
    end

    // R5: fraction and integer change on every update
    lf = 32'hACE1_2468;
    for (int i = 0; i < 250; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(8'(30 + (i % 150)), lf, "R5 varying input");
    end
    idle(2);

    // R1 again, then R9 long-run mean
    do_reset();
    check(div == 8'd0, "R1 second reset", int'(div), 0);
    corr_sum = 0;
    for (int i = 0; i < 3000; i++) step(8'd40, 32'h2AAA_AAAB, "R9 run");
    idle(2);
    ideal = (longint'(3000) * longint'(32'h2AAA_AAAB)) >>> 32;
    diff  = corr_sum - ideal;
    check(diff <= 7 && diff >= -7, "R9 mean", int'(corr_sum), int'(ideal));

    check(exp_q.size() == 0, "queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule